// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This unit resolves the control-flow instructions of a packet-filter virtual machine core. Each cycle it receives one decoded 8-bit opcode together with a signed 16-bit offset, a 32-bit immediate, the values of the destination and source registers, and a valid strobe. From these it works out whether the branch is taken and what the next program counter is. It also raises a call request, a program-exit request or an illegal-instruction flag.

Opcode bits [2:0] give the class: 5 selects full 64-bit comparisons and 6 selects comparisons of the low 32 bits only. Bit 3 chooses the second operand, with 0 for the sign-extended immediate and 1 for the source register. Bits [7:4] give the condition. The unit only signals function calls and program exits; the surrounding core carries them out.

A small program-counter register is part of the unit. It counts 64-bit instruction slots, resets to zero and loads the computed next value on every cycle in which the stall input is low. The request outputs are combinational, qualified only by the valid strobe, and do not depend on stall.

Top module: `jump_resolver`

## Requirements
- R1: After a synchronous active-low reset the program counter output `pc` reads 0.
- R2: Class 5 compares all 64 bits of both operands. Class 6 compares only bits [31:0], so the upper halves have no effect on the outcome.
- R3: Opcode bit 3 = 0 compares against the immediate, sign-extended to the comparison width. Bit 3 = 1 compares against `src_val`.
- R4: Unsigned conditions, by code in bits [7:4]: 0x2 greater, 0x3 greater-or-equal, 0xA less, 0xB less-or-equal.
- R5: Signed conditions, by code in bits [7:4]: 0x6 greater, 0x7 greater-or-equal, 0xC less, 0xD less-or-equal.
- R6: Code 0x1 is taken when the operands are equal, code 0x5 when they differ, and code 0x4 when their bitwise AND is nonzero.
- R7: A taken branch sets `next_pc` to pc+1+offset, with the offset sign-extended and the sum wrapping modulo 2^PC_W. A branch not taken sets `next_pc` to pc+1.
- R8: Code 0x0 in class 5 is always taken.
- R9: Code 0x8 in class 5 or 6 raises `call_req` with `call_target` equal to the immediate. It is not taken and `next_pc` is pc+1.
- R10: Code 0x9 in class 5 raises `exit_req`, and `next_pc` equals `pc` so the counter holds.
- R11: Code 0x0 or 0x9 in class 6, code 0xE or 0xF, or any class other than 5 or 6 raises `illegal`. Such an instruction is not taken, raises no request and holds `pc`.
- R12: While `stall` is high, `pc` keeps its value. The combinational outputs are still evaluated.
- R13: With `instr_valid` low, `taken`, `call_req`, `exit_req` and `illegal` are 0 and `next_pc` equals `pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stall | input | 1 | Freezes the program counter |
| instr_valid | input | 1 | An instruction is presented this cycle |
| opcode | input | 8 | Condition [7:4], source select [3], class [2:0] |
| offset | input | 16 | Signed branch displacement in slots |
| imm | input | 32 | Immediate operand and call target |
| dst_val | input | 64 | Destination register value |
| src_val | input | 64 | Source register value |
| pc | output | PC_W | Current program counter |
| next_pc | output | PC_W | Program counter for the following cycle |
| taken | output | 1 | Branch taken |
| call_req | output | 1 | Function call requested |
| call_target | output | 32 | Call target (the immediate) |
| exit_req | output | 1 | Program exit requested |
| illegal | output | 1 | Illegal jump-class encoding |

## Verification
The collision that matters most is a stall arriving in the same cycle as a taken branch, an exit or a call. The resolution outputs must still show the branch decision and target while the counter refuses to move. The bench provokes this with directed cases that pair a stall with a taken jump and with a call. Random stimulus also raises stall on about a fifth of the cycles. Each case is judged twice: the combinational outputs are compared in the presenting cycle, and `pc` is compared after the edge against a model counter that advances only when stall was low.

// File: rtl/jr_pkg.sv
// Shared encodings for the jump resolver.
// Assumes the opcode layout: condition [7:4], source select [3], class [2:0].
package jr_pkg;

    typedef enum logic [3:0] {
        OP_ALWAYS = 4'h0,
        OP_EQ     = 4'h1,
        OP_UGT    = 4'h2,
        OP_UGE    = 4'h3,
        OP_ANYBIT = 4'h4,
        OP_NE     = 4'h5,
        OP_SGT    = 4'h6,
        OP_SGE    = 4'h7,
        OP_INVOKE = 4'h8,
        OP_LEAVE  = 4'h9,
        OP_ULT    = 4'hA,
        OP_ULE    = 4'hB,
        OP_SLT    = 4'hC,
        OP_SLE    = 4'hD
    } jop_e;

    localparam logic [2:0] CLS_WIDE   = 3'd5;
    localparam logic [2:0] CLS_NARROW = 3'd6;

    typedef enum logic [1:0] {
        NX_SEQ    = 2'd0,
        NX_BRANCH = 2'd1,
        NX_HOLD   = 2'd2
    } nxt_e;

endpackage

// File: rtl/jr_compare.sv
// Condition evaluator: picks the second operand, narrows both to the
// selected width and evaluates the condition code.
// Assumes: the immediate is sign-extended to the comparison width;
// codes without a comparison yield cond = 1 for OP_ALWAYS and 0 otherwise.
module jr_compare
    import jr_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 32
) (
    input  logic [3:0]        code,
    input  logic              narrow,
    input  logic              use_reg,
    input  logic [IMM_W-1:0]  imm,
    input  logic [DATA_W-1:0] dst_val,
    input  logic [DATA_W-1:0] src_val,
    output logic              cond
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0]        b_raw;
    logic [DATA_W-1:0]        ua, ub;
    logic signed [DATA_W-1:0] sa, sb;

    // Choose the second operand: sign-extended immediate or register.
    always_comb begin
        if (use_reg) b_raw = src_val;
        else         b_raw = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
    end

    // Narrow to the low half for class 6, as unsigned and signed views.
    always_comb begin
        if (narrow) begin
            ua = {{HALF_W{1'b0}}, dst_val[HALF_W-1:0]};
            ub = {{HALF_W{1'b0}}, b_raw[HALF_W-1:0]};
            sa = {{HALF_W{dst_val[HALF_W-1]}}, dst_val[HALF_W-1:0]};
            sb = {{HALF_W{b_raw[HALF_W-1]}}, b_raw[HALF_W-1:0]};
        end else begin
            ua = dst_val;
            ub = b_raw;
            sa = dst_val;
            sb = b_raw;
        end
    end

    // Evaluate the condition selected by the code.
    always_comb begin
        unique case (code)
            OP_ALWAYS: cond = 1'b1;
            OP_EQ:     cond = (ua == ub);
            OP_NE:     cond = (ua != ub);
            OP_ANYBIT: cond = |(ua & ub);
            OP_UGT:    cond = (ua > ub);
            OP_UGE:    cond = (ua >= ub);
            OP_ULT:    cond = (ua < ub);
            OP_ULE:    cond = (ua <= ub);
            OP_SGT:    cond = (sa > sb);
            OP_SGE:    cond = (sa >= sb);
            OP_SLT:    cond = (sa < sb);
            OP_SLE:    cond = (sa <= sb);
            default:   cond = 1'b0;
        endcase
    end

endmodule

// File: rtl/jr_next_pc.sv
// Next program counter: sequential step, relative branch, or hold.
// Assumes the counter counts instruction slots and wraps modulo 2^PC_W.
module jr_next_pc
    import jr_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int OFF_W = 16
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [OFF_W-1:0] offset,
    input  nxt_e             kind,
    output logic [PC_W-1:0]  next_pc
);
    logic [PC_W-1:0] step;
    logic [PC_W-1:0] disp;

    // The successor slot and the sign-extended displacement.
    always_comb begin
        step = pc + PC_W'(1);
        disp = {{(PC_W-OFF_W){offset[OFF_W-1]}}, offset};
    end

    // Select the next counter value by kind.
    always_comb begin
        unique case (kind)
            NX_BRANCH: next_pc = step + disp;
            NX_SEQ:    next_pc = step;
            default:   next_pc = pc;
        endcase
    end

endmodule

// File: rtl/jr_pc_reg.sv
// Program counter register: synchronous active-low reset to 0, loads
// next value when stall is low and keeps its value when stall is high.
module jr_pc_reg #(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stall,
    input  logic [PC_W-1:0] d,
    output logic [PC_W-1:0] q
);
    // Hold the counter, updating only on unstalled cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= '0;
        else if (!stall) q <= d;
    end

    // R12: a stalled cycle leaves the counter unchanged.
    p_stall_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(q));

endmodule

// File: rtl/jump_resolver.sv
// Jump resolver top: decodes class and condition, flags illegal
// encodings, raises call and exit requests and steps the counter.
// Assumes one instruction per valid cycle; requests are combinational
// and are not gated by stall.
module jump_resolver
    import jr_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int DATA_W = 64,
    parameter int IMM_W  = 32,
    parameter int OFF_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              instr_valid,
    input  logic [7:0]        opcode,
    input  logic [OFF_W-1:0]  offset,
    input  logic [IMM_W-1:0]  imm,
    input  logic [DATA_W-1:0] dst_val,
    input  logic [DATA_W-1:0] src_val,
    output logic [PC_W-1:0]   pc,
    output logic [PC_W-1:0]   next_pc,
    output logic              taken,
    output logic              call_req,
    output logic [IMM_W-1:0]  call_target,
    output logic              exit_req,
    output logic              illegal
);
    logic [3:0] code;
    logic [2:0] cls;
    logic       use_reg;
    logic       narrow;
    logic       bad;
    logic       cond;
    logic       is_invoke, is_leave;
    nxt_e       kind;

    // Split the opcode into its fields.
    always_comb begin
        code    = opcode[7:4];
        use_reg = opcode[3];
        cls     = opcode[2:0];
        narrow  = (cls == CLS_NARROW);
    end

    // Flag encodings that are not legal jump-class instructions.
    always_comb begin
        bad = 1'b0;
        if (cls != CLS_WIDE && cls != CLS_NARROW)               bad = 1'b1;
        if (code > 4'hD)                                        bad = 1'b1;
        if (narrow && (code == OP_ALWAYS || code == OP_LEAVE))  bad = 1'b1;
    end

    jr_compare #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_cmp (
        .code    (code),
        .narrow  (narrow),
        .use_reg (use_reg),
        .imm     (imm),
        .dst_val (dst_val),
        .src_val (src_val),
        .cond    (cond)
    );

    // Raise the outputs for a valid instruction and pick the counter step.
    always_comb begin
        is_invoke   = (code == OP_INVOKE);
        is_leave    = (code == OP_LEAVE);
        illegal     = instr_valid && bad;
        call_req    = instr_valid && !bad && is_invoke;
        exit_req    = instr_valid && !bad && is_leave;
        taken       = instr_valid && !bad && !is_invoke && !is_leave && cond;
        call_target = imm;
        if (!instr_valid || bad || is_leave) kind = NX_HOLD;
        else if (taken)                      kind = NX_BRANCH;
        else                                 kind = NX_SEQ;
    end

    jr_next_pc #(.PC_W(PC_W), .OFF_W(OFF_W)) u_nxt (
        .pc      (pc),
        .offset  (offset),
        .kind    (kind),
        .next_pc (next_pc)
    );

    jr_pc_reg #(.PC_W(PC_W)) u_pc (
        .clk   (clk),
        .rst_n (rst_n),
        .stall (stall),
        .d     (next_pc),
        .q     (pc)
    );

    // R11: at most one of the four outcomes in any cycle.
    p_one_outcome_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({taken, call_req, exit_req, illegal}));

    // R10: an unstalled exit leaves the counter where it was.
    p_exit_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (exit_req && !stall) |=> (pc == $past(pc)));

    // R7: an unstalled, not-taken, non-exit, legal instruction steps by one.
    p_seq_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !stall && !taken && !exit_req && !illegal)
        |=> (pc == $past(pc) + PC_W'(1)));

    // R13: with no instruction the counter does not move.
    p_idle_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!instr_valid && !stall) |=> $stable(pc));

    // R11: an illegal instruction never moves the counter.
    p_illegal_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> $stable(pc));

endmodule

// File: tb/tb_jump_resolver.sv
`timescale 1ns/1ps
module tb_jump_resolver;
    localparam int PC_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              stall = 1'b0;
    logic              instr_valid = 1'b0;
    logic [7:0]        opcode = '0;
    logic [15:0]       offset = '0;
    logic [31:0]       imm = '0;
    logic [63:0]       dst_val = '0;
    logic [63:0]       src_val = '0;
    logic [PC_W-1:0]   pc, next_pc;
    logic              taken, call_req, exit_req, illegal;
    logic [31:0]       call_target;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    logic [PC_W-1:0] model_pc = '0;

    always #2 clk = ~clk;

    jump_resolver dut (
        .clk(clk), .rst_n(rst_n), .stall(stall), .instr_valid(instr_valid),
        .opcode(opcode), .offset(offset), .imm(imm), .dst_val(dst_val),
        .src_val(src_val), .pc(pc), .next_pc(next_pc), .taken(taken),
        .call_req(call_req), .call_target(call_target), .exit_req(exit_req),
        .illegal(illegal)
    );

    typedef struct packed {
        logic            tk;
        logic            cl;
        logic            ex;
        logic            il;
        logic [PC_W-1:0] nx;
    } exp_t;

    // Reference model built from the requirements.
    function automatic exp_t model(input logic v, input logic [7:0] op,
                                   input logic [15:0] off, input logic [31:0] im,
                                   input logic [63:0] d, input logic [63:0] s,
                                   input logic [PC_W-1:0] p);
        exp_t e;
        logic [3:0] c = op[7:4];
        logic [2:0] k = op[2:0];
        logic [63:0] b;
        longint unsigned ua, ub;
        longint sa, sb;
        logic cnd;
        e = '0;
        e.nx = p;
        if (!v) return e;
        if ((k != 3'd5 && k != 3'd6) || c > 4'hD || (k == 3'd6 && (c == 4'h0 || c == 4'h9))) begin
            e.il = 1'b1;
            return e;
        end
        b = op[3] ? s : {{32{im[31]}}, im};
        if (k == 3'd6) begin
            ua = {32'h0, d[31:0]};
            ub = {32'h0, b[31:0]};
            sa = longint'($signed(d[31:0]));
            sb = longint'($signed(b[31:0]));
        end else begin
            ua = d; ub = b; sa = $signed(d); sb = $signed(b);
        end
        case (c)
            4'h0: cnd = 1;
            4'h1: cnd = (ua == ub);
            4'h5: cnd = (ua != ub);
            4'h4: cnd = ((ua & ub) != 0);
            4'h2: cnd = (ua > ub);
            4'h3: cnd = (ua >= ub);
            4'hA: cnd = (ua < ub);
            4'hB: cnd = (ua <= ub);
            4'h6: cnd = (sa > sb);
            4'h7: cnd = (sa >= sb);
            4'hC: cnd = (sa < sb);
            4'hD: cnd = (sa <= sb);
            default: cnd = 0;
        endcase
        if (c == 4'h8) begin
            e.cl = 1; e.nx = p + 1;
        end else if (c == 4'h9) begin
            e.ex = 1;
        end else if (cnd) begin
            e.tk = 1; e.nx = p + 1 + {{16{off[15]}}, off};
        end else begin
            e.nx = p + 1;
        end
        return e;
    endfunction

    // Requirement tag covering an opcode.
    function automatic string tag_of(input logic [7:0] op);
        logic [3:0] c = op[7:4];
        logic [2:0] k = op[2:0];
        if ((k != 3'd5 && k != 3'd6) || c > 4'hD || (k == 3'd6 && (c == 4'h0 || c == 4'h9))) return "R11";
        case (c)
            4'h0: return "R8";
            4'h8: return "R9";
            4'h9: return "R10";
            4'h1, 4'h4, 4'h5: return "R6";
            4'h2, 4'h3, 4'hA, 4'hB: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Present one instruction, check its outputs, then the counter after the edge.
    task automatic run_one(input logic v, input logic [7:0] op, input logic [15:0] off,
                           input logic [31:0] im, input logic [63:0] d,
                           input logic [63:0] s, input logic st, input string req);
        exp_t e;
        @(negedge clk);
        instr_valid = v; opcode = op; offset = off; imm = im;
        dst_val = d; src_val = s; stall = st;
        #1;
        e = model(v, op, off, im, d, s, model_pc);
        check({taken, call_req, exit_req, illegal} == {e.tk, e.cl, e.ex, e.il}, req,
              "flags tk/cl/ex/il", 64'({taken, call_req, exit_req, illegal}),
              64'({e.tk, e.cl, e.ex, e.il}));
        check(next_pc == e.nx, req, "next_pc", 64'(next_pc), 64'(e.nx));
        if (e.cl) check(call_target == im, "R9", "call_target", 64'(call_target), 64'(im));
        @(posedge clk);
        #1;
        if (!st) model_pc = e.nx;
        check(pc == model_pc, st ? "R12" : req, "pc", 64'(pc), 64'(model_pc));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; instr_valid = 0; stall = 0;
        @(posedge clk); @(posedge clk);
        #1;
        model_pc = '0;
        check(pc == '0, "R1", "pc after reset", 64'(pc), 64'h0);
        @(negedge clk);
        rst_n = 1;
    endtask

    initial begin : watchdog
        #(4 * 150000);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd4711);
        do_reset();

        // R8 jump forward; R7 offset arithmetic
        run_one(1, 8'h05, 16'd100, 0, 0, 0, 0, "R8");
        // R7 negative offset, wrap below zero
        run_one(1, 8'h05, 16'hFF00, 0, 0, 0, 0, "R7");
        // R2 upper halves ignored in class 6, seen in class 5
        run_one(1, 8'h1E, 16'd5, 0, 64'hFFFF_FFFF_0000_0005, 64'h0000_0001_0000_0005, 0, "R2");
        run_one(1, 8'h1D, 16'd5, 0, 64'hFFFF_FFFF_0000_0005, 64'h0000_0001_0000_0005, 0, "R2");
        // R3 immediate sign extended to 64 bits
        run_one(1, 8'h15, 16'd3, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, "R3");
        // R3 register source used when bit 3 set
        run_one(1, 8'h1D, 16'd3, 32'h1, 64'h7, 64'h7, 0, "R3");
        // R4 vs R5 on all-ones versus one
        run_one(1, 8'h2D, 16'd2, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 0, "R4");
        run_one(1, 8'h6D, 16'd2, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 0, "R5");
        // R6 bit test with disjoint and shared bits
        run_one(1, 8'h45, 16'd4, 32'h0F0, 64'h00F, 0, 0, "R6");
        run_one(1, 8'h45, 16'd4, 32'h0F0, 64'h010, 0, 0, "R6");
        // R9 call, in both classes
        run_one(1, 8'h85, 16'd9, 32'hDEAD_0001, 0, 0, 0, "R9");
        run_one(1, 8'h86, 16'd9, 32'h0000_0042, 0, 0, 0, "R9");
        // R10 exit holds
        run_one(1, 8'h95, 16'd9, 0, 0, 0, 0, "R10");
        // R11 illegal encodings
        run_one(1, 8'h06, 16'd9, 0, 0, 0, 0, "R11");
        run_one(1, 8'h96, 16'd9, 0, 0, 0, 0, "R11");
        run_one(1, 8'hE5, 16'd9, 0, 0, 0, 0, "R11");
        run_one(1, 8'h14, 16'd9, 0, 0, 0, 0, "R11");
        // R12 stall with a taken jump and with a call
        run_one(1, 8'h05, 16'd50, 0, 0, 0, 1, "R12");
        run_one(1, 8'h85, 16'd50, 32'h5, 0, 0, 1, "R12");
        // R13 nothing valid
        run_one(0, 8'h05, 16'd50, 0, 0, 0, 0, "R13");

        for (int i = 0; i < 400; i++) begin
            logic [3:0]  c  = 4'($urandom_range(0, 15));
            logic [2:0]  k  = ($urandom_range(0, 9) == 0) ? 3'($urandom) : (($urandom_range(0, 1) == 0) ? 3'd5 : 3'd6);
            logic [7:0]  op = {c, 1'($urandom), k};
            logic [63:0] d  = {$urandom, $urandom};
            logic [63:0] s  = ($urandom_range(0, 3) == 0) ? d : {$urandom, $urandom};
            logic [31:0] im = ($urandom_range(0, 3) == 0) ? d[31:0] : $urandom;
            logic        v  = ($urandom_range(0, 9) != 0);
            logic        st = ($urandom_range(0, 4) == 0);
            run_one(v, op, 16'($urandom), im, d, s, st, v ? (st ? "R12" : tag_of(op)) : "R13");
            if (i == 200) do_reset();
        end

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule